// File: doc/BRIEF.md
# Framer Loopback Mode Selector

This block sits between a DS3/E3 framer core and its line interface and steers symbols along one of three loopback paths, or none. Line loopback sends the received rails straight back to the line. Diagnostic loopback sends the transmit framer's rails into the receive framer. Payload loopback feeds the received payload into the transmit framer, which adds fresh overhead. In payload loopback the transmit side runs on receive timing. Everything runs on one clock, and each rail stream carries its own clock-enable.

Software writes three mode bits. A small control unit checks them against the combination rules and applies the legal result on the next receive clock-enable. Payload and diagnostic loopback cannot be active together, so payload loopback wins a conflict and a sticky error flag records it. Line loopback can be combined with either of the other two modes. When line and payload loopback are both on, the line rails and line timing come from the receive side while the core paths stay in payload loopback. Each transmit line rail has its own force-high and invert controls.

Top module: `lb_loopback_sel`

## Requirements
- R1: After reset all loopbacks are off and errStatus is 0. With no loopback active, lineTx rails and clock-enable come from txCore, coreRx comes from rx, coreTxData/coreTxClkEn come from sysTxData/sysTxClkEn, and sysTxSof/sysTxDen come from txCoreSof/txCoreDen.
- R2: The mode bits take effect only at a rising clk edge where rxClkEn is 1. While rxClkEn stays 0, the previous mode stays in force.
- R3: If cfgPayLb and cfgDiagLb are both 1 when applied, payload loopback is active and diagnostic loopback is not, so coreRx keeps coming from rx.
- R4: errStatus becomes 1 at an edge where both cfgPayLb and cfgDiagLb are 1 and rxClkEn is 1. It then stays 1 until an edge with errClr at 1 and no such conflict, which clears it.
- R5: In line loopback, lineTxPos/lineTxNeg/lineTxClkEn equal rxPos/rxNeg/rxClkEn before the force and invert stage, and txAisReq has no effect on the line.
- R6: In every mode the output rail is lineTxPos = forcePosHigh | (basePos ^ invertPos), and lineTxNeg is formed the same way from forceNegHigh and invertNeg.
- R7: In diagnostic loopback, coreRxPos/coreRxNeg/coreRxClkEn equal txCorePos/txCoreNeg/txCoreClkEn, and the line keeps receiving the transmit (or AIS) signal.
- R8: Line and diagnostic loopback active together apply both paths at once.
- R9: When line loopback is off and txAisReq is 1, the base rails are positive 1 and negative 0.
- R10: In payload loopback, coreTxData equals rxPayData and coreTxClkEn equals rxClkEn, so sysTxData and sysTxClkEn are ignored. lineTxClkEn equals rxClkEn.
- R11: In payload loopback, sysTxSof and sysTxDen equal rxSof and rxDen.
- R12: With line and payload loopback both active, the line rails and clock-enable come from rx, while coreTxData, coreTxClkEn, sysTxSof and sysTxDen follow payload loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLineLb | input | 1 | Requested line loopback |
| cfgDiagLb | input | 1 | Requested diagnostic loopback |
| cfgPayLb | input | 1 | Requested payload loopback |
| errClr | input | 1 | Clears the conflict flag |
| forcePosHigh | input | 1 | Force positive line rail to 1 |
| invertPos | input | 1 | Invert positive line rail |
| forceNegHigh | input | 1 | Force negative line rail to 1 |
| invertNeg | input | 1 | Invert negative line rail |
| txAisReq | input | 1 | Transmit AIS request |
| rxPos | input | 1 | Received positive rail |
| rxNeg | input | 1 | Received negative rail |
| rxClkEn | input | 1 | Receive clock-enable |
| txCorePos | input | 1 | Transmit framer positive rail |
| txCoreNeg | input | 1 | Transmit framer negative rail |
| txCoreClkEn | input | 1 | Transmit framer clock-enable |
| txCoreSof | input | 1 | Transmit framer start of frame |
| txCoreDen | input | 1 | Transmit framer data enable |
| rxPayData | input | PAY_W | Receive framer payload |
| rxSof | input | 1 | Receive start of frame |
| rxDen | input | 1 | Receive data enable |
| sysTxData | input | PAY_W | System transmit data |
| sysTxClkEn | input | 1 | System transmit clock-enable |
| lineTxPos | output | 1 | Line positive rail |
| lineTxNeg | output | 1 | Line negative rail |
| lineTxClkEn | output | 1 | Line transmit clock-enable |
| coreRxPos | output | 1 | Receive framer positive rail |
| coreRxNeg | output | 1 | Receive framer negative rail |
| coreRxClkEn | output | 1 | Receive framer clock-enable |
| coreTxData | output | PAY_W | Transmit framer data input |
| coreTxClkEn | output | 1 | Transmit framer clock-enable |
| sysTxSof | output | 1 | Start of frame toward system |
| sysTxDen | output | 1 | Data enable toward system |
| errStatus | output | 1 | Sticky conflict flag |

## Verification
The bench applies every one of the eight mode-bit combinations and, in each mode, walks through all patterns of the one-bit rail, timing and force inputs. This catches three kinds of fault. A selector that let diagnostic loopback win over payload would feed transmit rails into coreRx. One that combined line and payload loopback wrongly would put core rails on the line. One that let AIS through in line loopback would drive the positive rail high. Separate sequences hold rxClkEn low while the mode bits change, which exposes a mode register that ignores the enable. They also clear the conflict flag while the conflict is still present and again once it has gone, which exposes a flag that is not sticky or does not clear.

// File: rtl/lb_pkg.sv
package lb_pkg;
  // Control-to-datapath strobes: the loopback paths in force
  typedef struct packed {
    logic lineLb;
    logic diagLb;
    logic payLb;
  } lbModeT;
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cfgLineLb,
  input  logic   cfgDiagLb,
  input  logic   cfgPayLb,
  input  logic   updEn,
  input  logic   errClr,
  output lbModeT modeNow,
  output logic   errStatus
);
  lbModeT modeQ, modeReq;
  logic   errQ;
  logic   conflict;

  always_comb begin
    conflict       = cfgPayLb & cfgDiagLb;
    modeReq.lineLb = cfgLineLb;
    modeReq.payLb  = cfgPayLb;
    modeReq.diagLb = cfgDiagLb & ~cfgPayLb;  // payload wins
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (updEn) modeQ <= modeReq;
      if (updEn && conflict) errQ <= 1'b1;
      else if (errClr)       errQ <= 1'b0;
    end
  end

  assign modeNow   = modeQ;
  assign errStatus = errQ;
endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  lbModeT             modeNow,
  input  logic               forcePosHigh,
  input  logic               invertPos,
  input  logic               forceNegHigh,
  input  logic               invertNeg,
  input  logic               txAisReq,
  input  logic               rxPos,
  input  logic               rxNeg,
  input  logic               rxClkEn,
  input  logic               txCorePos,
  input  logic               txCoreNeg,
  input  logic               txCoreClkEn,
  input  logic               txCoreSof,
  input  logic               txCoreDen,
  input  logic [PAY_W-1:0]   rxPayData,
  input  logic               rxSof,
  input  logic               rxDen,
  input  logic [PAY_W-1:0]   sysTxData,
  input  logic               sysTxClkEn,
  output logic               lineTxPos,
  output logic               lineTxNeg,
  output logic               lineTxClkEn,
  output logic               coreRxPos,
  output logic               coreRxNeg,
  output logic               coreRxClkEn,
  output logic [PAY_W-1:0]   coreTxData,
  output logic               coreTxClkEn,
  output logic               sysTxSof,
  output logic               sysTxDen
);
  logic basePos, baseNeg;

  // Line side: receive echo, otherwise core transmit with AIS override
  always_comb begin
    if (modeNow.lineLb) begin
      basePos = rxPos;
      baseNeg = rxNeg;
    end else if (txAisReq) begin
      basePos = 1'b1;
      baseNeg = 1'b0;
    end else begin
      basePos = txCorePos;
      baseNeg = txCoreNeg;
    end
    lineTxClkEn = (modeNow.lineLb | modeNow.payLb) ? rxClkEn : txCoreClkEn;
    lineTxPos   = forcePosHigh | (basePos ^ invertPos);
    lineTxNeg   = forceNegHigh | (baseNeg ^ invertNeg);
  end

  // Receive framer input: transmit rails in diagnostic loopback
  always_comb begin
    coreRxPos   = modeNow.diagLb ? txCorePos   : rxPos;
    coreRxNeg   = modeNow.diagLb ? txCoreNeg   : rxNeg;
    coreRxClkEn = modeNow.diagLb ? txCoreClkEn : rxClkEn;
  end

  // Transmit framer input and system timing in payload loopback
  always_comb begin
    coreTxData  = modeNow.payLb ? rxPayData : sysTxData;
    coreTxClkEn = modeNow.payLb ? rxClkEn   : sysTxClkEn;
    sysTxSof    = modeNow.payLb ? rxSof     : txCoreSof;
    sysTxDen    = modeNow.payLb ? rxDen     : txCoreDen;
  end
endmodule

// File: rtl/lb_loopback_sel.sv
module lb_loopback_sel
  import lb_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLineLb,
  input  logic             cfgDiagLb,
  input  logic             cfgPayLb,
  input  logic             errClr,
  input  logic             forcePosHigh,
  input  logic             invertPos,
  input  logic             forceNegHigh,
  input  logic             invertNeg,
  input  logic             txAisReq,
  input  logic             rxPos,
  input  logic             rxNeg,
  input  logic             rxClkEn,
  input  logic             txCorePos,
  input  logic             txCoreNeg,
  input  logic             txCoreClkEn,
  input  logic             txCoreSof,
  input  logic             txCoreDen,
  input  logic [PAY_W-1:0] rxPayData,
  input  logic             rxSof,
  input  logic             rxDen,
  input  logic [PAY_W-1:0] sysTxData,
  input  logic             sysTxClkEn,
  output logic             lineTxPos,
  output logic             lineTxNeg,
  output logic             lineTxClkEn,
  output logic             coreRxPos,
  output logic             coreRxNeg,
  output logic             coreRxClkEn,
  output logic [PAY_W-1:0] coreTxData,
  output logic             coreTxClkEn,
  output logic             sysTxSof,
  output logic             sysTxDen,
  output logic             errStatus
);
  lbModeT modeNow;

  lb_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgLineLb(cfgLineLb), .cfgDiagLb(cfgDiagLb), .cfgPayLb(cfgPayLb),
    .updEn(rxClkEn), .errClr(errClr),
    .modeNow(modeNow), .errStatus(errStatus)
  );

  lb_datapath #(.PAY_W(PAY_W)) uPath (
    .modeNow(modeNow),
    .forcePosHigh(forcePosHigh), .invertPos(invertPos),
    .forceNegHigh(forceNegHigh), .invertNeg(invertNeg),
    .txAisReq(txAisReq),
    .rxPos(rxPos), .rxNeg(rxNeg), .rxClkEn(rxClkEn),
    .txCorePos(txCorePos), .txCoreNeg(txCoreNeg), .txCoreClkEn(txCoreClkEn),
    .txCoreSof(txCoreSof), .txCoreDen(txCoreDen),
    .rxPayData(rxPayData), .rxSof(rxSof), .rxDen(rxDen),
    .sysTxData(sysTxData), .sysTxClkEn(sysTxClkEn),
    .lineTxPos(lineTxPos), .lineTxNeg(lineTxNeg), .lineTxClkEn(lineTxClkEn),
    .coreRxPos(coreRxPos), .coreRxNeg(coreRxNeg), .coreRxClkEn(coreRxClkEn),
    .coreTxData(coreTxData), .coreTxClkEn(coreTxClkEn),
    .sysTxSof(sysTxSof), .sysTxDen(sysTxDen)
  );
endmodule

// File: rtl/lb_sel_checker.sv
module lb_sel_checker
  import lb_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input lbModeT modeNow,
  input logic   cfgPayLb,
  input logic   cfgDiagLb,
  input logic   rxClkEn,
  input logic   rxSof,
  input logic   rxDen,
  input logic   forcePosHigh,
  input logic   lineTxPos,
  input logic   lineTxClkEn,
  input logic   coreTxClkEn,
  input logic   sysTxSof,
  input logic   sysTxDen,
  input logic   errStatus
);
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxClkEn |=> $stable(modeNow)); // R2
  AST_PAY_DIAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.payLb |-> !modeNow.diagLb); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errStatus) |-> $past(cfgPayLb && cfgDiagLb && rxClkEn)); // R4
  AST_LINE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.lineLb |-> (lineTxClkEn == rxClkEn)); // R5
  AST_FORCE_POS: assert property (@(posedge clk) disable iff (!rstN)
    forcePosHigh |-> lineTxPos); // R6
  AST_PAY_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.payLb |-> (coreTxClkEn == rxClkEn)); // R10
  AST_PAY_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.payLb |-> (sysTxSof == rxSof && sysTxDen == rxDen)); // R11
endmodule

bind lb_loopback_sel lb_sel_checker uChk (
  .clk(clk), .rstN(rstN), .modeNow(modeNow),
  .cfgPayLb(cfgPayLb), .cfgDiagLb(cfgDiagLb), .rxClkEn(rxClkEn),
  .rxSof(rxSof), .rxDen(rxDen), .forcePosHigh(forcePosHigh),
  .lineTxPos(lineTxPos), .lineTxClkEn(lineTxClkEn), .coreTxClkEn(coreTxClkEn),
  .sysTxSof(sysTxSof), .sysTxDen(sysTxDen), .errStatus(errStatus)
);

// File: tb/tb_lb_loopback_sel.sv
module tb_lb_loopback_sel;
  localparam int CLK_PERIOD = 10;
  localparam int PAY_W = 8;
  localparam int VEC_BITS = 13;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLineLb = 0, cfgDiagLb = 0, cfgPayLb = 0, errClr = 0;
  logic forcePosHigh = 0, invertPos = 0, forceNegHigh = 0, invertNeg = 0;
  logic txAisReq = 0, rxPos = 0, rxNeg = 0, rxClkEn = 0;
  logic txCorePos = 0, txCoreNeg = 0, txCoreClkEn = 0, txCoreSof = 0, txCoreDen = 0;
  logic [PAY_W-1:0] rxPayData = '0, sysTxData = '0;
  logic rxSof = 0, rxDen = 0, sysTxClkEn = 0;
  logic lineTxPos, lineTxNeg, lineTxClkEn, coreRxPos, coreRxNeg, coreRxClkEn;
  logic [PAY_W-1:0] coreTxData;
  logic coreTxClkEn, sysTxSof, sysTxDen, errStatus;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb_loopback_sel #(.PAY_W(PAY_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic applyMode(input logic l, input logic d, input logic p);
    @(negedge clk);
    cfgLineLb = l; cfgDiagLb = d; cfgPayLb = p; rxClkEn = 1'b1;
    @(negedge clk);
    rxClkEn = 1'b0;
  endtask

  task automatic driveVec(input int v);
    rxPos = v[0]; rxNeg = v[1]; rxClkEn = v[2];
    txCorePos = v[3]; txCoreNeg = v[4]; txCoreClkEn = v[5];
    txAisReq = v[6]; forcePosHigh = v[7]; invertPos = v[8];
    forceNegHigh = v[9]; invertNeg = v[10]; txCoreSof = v[11]; rxSof = v[12];
    txCoreDen = v[0] ^ v[11]; rxDen = v[1] ^ v[12]; sysTxClkEn = ~v[5];
    rxPayData = PAY_W'(v * 3); sysTxData = ~PAY_W'(v);
  endtask

  // Expected outputs from the requirements
  task automatic checkAll(input logic l, input logic d, input logic p);
    logic dEff, bp, bn;
    string tagLine, tagRx, tagTx;
    dEff = d & ~p;
    bp = l ? rxPos : (txAisReq ? 1'b1 : txCorePos);
    bn = l ? rxNeg : (txAisReq ? 1'b0 : txCoreNeg);
    tagLine = (l && p) ? "R12" : l ? "R5" : txAisReq ? "R9" : "R6";
    tagRx   = (d && l) ? "R8" : (d && p) ? "R3" : d ? "R7" : "R1";
    tagTx   = p ? "R10" : "R1";
    chk({tagLine, " line rails"}, {30'd0, lineTxPos, lineTxNeg},
        {30'd0, forcePosHigh | (bp ^ invertPos), forceNegHigh | (bn ^ invertNeg)});
    chk({tagTx, " line clken"}, {31'd0, lineTxClkEn}, {31'd0, (l | p) ? rxClkEn : txCoreClkEn});
    chk({tagRx, " core rx"}, {29'd0, coreRxPos, coreRxNeg, coreRxClkEn},
        dEff ? {29'd0, txCorePos, txCoreNeg, txCoreClkEn} : {29'd0, rxPos, rxNeg, rxClkEn});
    chk({tagTx, " core tx"}, {23'd0, coreTxData, coreTxClkEn},
        p ? {23'd0, rxPayData, rxClkEn} : {23'd0, sysTxData, sysTxClkEn});
    chk(p ? "R11 sof/den" : "R1 sof/den", {30'd0, sysTxSof, sysTxDen},
        p ? {30'd0, rxSof, rxDen} : {30'd0, txCoreSof, txCoreDen});
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    driveVec(13'h0A5B & ~13'h4);
    #1;
    chk("R1 errStatus after reset", {31'd0, errStatus}, 32'd0);
    checkAll(1'b0, 1'b0, 1'b0);

    // R2: mode change held off while rxClkEn low
    applyMode(1'b0, 1'b0, 1'b0);
    driveVec(0);
    rxPos = 1'b1; txCorePos = 1'b0;
    cfgLineLb = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 mode held without rxClkEn", {31'd0, lineTxPos}, 32'd0);
    @(negedge clk); rxClkEn = 1'b1;
    @(negedge clk); rxClkEn = 1'b0;
    #1;
    chk("R2 mode applied on rxClkEn", {31'd0, lineTxPos}, 32'd1);

    // Sweep every mode combination over all input patterns
    for (int m = 0; m < 8; m++) begin
      applyMode(m[2], m[1], m[0]);
      for (int v = 0; v < (1 << VEC_BITS); v++) begin
        @(negedge clk);
        driveVec(v);
        #1;
        checkAll(m[2], m[1], m[0]);
      end
    end

    // R4: sticky conflict flag
    @(negedge clk); errClr = 1'b1; rxClkEn = 1'b0;
    @(negedge clk); errClr = 1'b0;
    #1;
    chk("R4 flag cleared", {31'd0, errStatus}, 32'd0);
    applyMode(1'b0, 1'b1, 1'b1);
    #1;
    chk("R4 flag set on conflict", {31'd0, errStatus}, 32'd1);
    @(negedge clk); errClr = 1'b1; rxClkEn = 1'b1;
    @(negedge clk); errClr = 1'b0; rxClkEn = 1'b0;
    #1;
    chk("R4 set wins over clear", {31'd0, errStatus}, 32'd1);
    applyMode(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    chk("R4 flag sticky after conflict gone", {31'd0, errStatus}, 32'd1);
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    #1;
    chk("R4 flag cleared by errClr", {31'd0, errStatus}, 32'd0);

    finish();
  end
endmodule